// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block drives the driver-enable line of a half-duplex RS-485 transceiver. It works from the status signals of a UART transmitter. When the host pushes a character into the transmit queue, the block marks the bus as owned at once. It keeps the line asserted while characters are still queued or being shifted. After the final stop bit it holds the line for a programmable tail of whole bit times and then releases it, so the far end sees the last stop bit complete before the driver turns off.

The direction signal can be steered onto either of the two modem-control outputs, and its active level can be inverted. The modem output that is not chosen keeps its ordinary value. A loopback mode has the highest priority and parks both outputs at their inactive high level. Below loopback comes direction control, and below that the normal modem-control values.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: While `cfg_auto_en` is 0 and `loopback` is 0, `rts_pin` equals `modem_rts_n` and `dtr_pin` equals `modem_dtr_n`.
- R2: With `cfg_auto_en`=1, direction drives `rts_pin` when `cfg_use_dtr`=0 and `dtr_pin` when `cfg_use_dtr`=1.
- R3: In the clock cycle after a cycle with `fifo_wr`=1, the selected pin is at its active level (0 when `cfg_invert`=0).
- R4: Once asserted, the direction stays active until a cycle in which `bit_tick`, `fifo_empty` and `shifter_idle` are all 1 (the end tick). Idle status between ticks has no effect.
- R5: With `cfg_tail`=N>0 sampled at the end tick, the pin is released in the cycle after the N-th later cycle with `bit_tick`=1.
- R6: With `cfg_tail`=0, the pin is released in the cycle after the end tick.
- R7: With `cfg_invert`=1, the active level is 1 and the released level is 0.
- R8: A `fifo_wr` during the tail cancels the countdown. The direction stays active, and a full tail is timed again from the next end tick.
- R9: While `loopback`=1, both `rts_pin` and `dtr_pin` are 1 whatever the other inputs are.
- R10: The pin that is not selected follows its modem input while direction control is enabled.
- R11: During and after synchronous reset `rst`, the direction is released (the selected pin is at its inactive level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_auto_en | input | 1 | Enables automatic direction control |
| cfg_use_dtr | input | 1 | 0: direction on RTS, 1: direction on DTR |
| cfg_invert | input | 1 | 1: direction active level is high |
| cfg_tail | input | DLY_W | Tail length in bit times after the last stop bit |
| loopback | input | 1 | Loopback mode, forces both pins high |
| modem_rts_n | input | 1 | Normal RTS level |
| modem_dtr_n | input | 1 | Normal DTR level |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| fifo_wr | input | 1 | Transmit queue write strobe |
| fifo_empty | input | 1 | Transmit queue is empty |
| shifter_idle | input | 1 | Transmit shifter has no character in flight |
| rts_pin | output | 1 | RTS output level |
| dtr_pin | output | 1 | DTR output level |

## Verification
The bench builds the block with the default 8-bit tail width. This makes the longest 255-bit tail reachable, and the bench runs it directed next to the zero-length tail. Bit ticks arrive every few clocks, so the bench can check that idle status between ticks does not release the line. Random frames mix tail lengths, busy spans, both polarities and both pin choices. A write during the tail checks that the countdown restarts.

// File: rtl/rs485dir_pkg.sv
package rs485dir_pkg;

    typedef enum logic [1:0] {
        DIR_IDLE = 2'd0,
        DIR_PEND = 2'd1,
        DIR_TAIL = 2'd2
    } dir_state_e;

    typedef struct packed {
        logic auto_en;
        logic use_dtr;
        logic invert;
    } dir_cfg_t;

    // Pin level for a direction state: low when active unless inverted.
    function automatic logic dir_level(input logic active, input logic invert);
        return ~(active ^ invert);
    endfunction

endpackage

// File: rtl/rs485dir_tracker.sv
module rs485dir_tracker
    import rs485dir_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             fifo_wr,
    input  logic             fifo_empty,
    input  logic             shifter_idle,
    input  logic [DLY_W-1:0] tail_cfg,
    output logic             dir_active
);

    localparam logic [DLY_W-1:0] CNT_ONE  = DLY_W'(1);
    localparam logic [DLY_W-1:0] CNT_ZERO = '0;

    dir_state_e       state_q, state_d;
    logic [DLY_W-1:0] cnt_q, cnt_d;
    logic             end_tick;

    assign end_tick = bit_tick & fifo_empty & shifter_idle;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DIR_IDLE: begin
                if (fifo_wr) state_d = DIR_PEND;
            end
            DIR_PEND: begin
                if (!fifo_wr && end_tick) begin
                    if (tail_cfg == CNT_ZERO) begin
                        state_d = DIR_IDLE;
                    end else begin
                        state_d = DIR_TAIL;
                        cnt_d   = tail_cfg;
                    end
                end
            end
            DIR_TAIL: begin
                if (fifo_wr) begin
                    state_d = DIR_PEND;
                end else if (bit_tick) begin
                    if (cnt_q == CNT_ONE) state_d = DIR_IDLE;
                    else                  cnt_d   = cnt_q - CNT_ONE;
                end
            end
            default: state_d = DIR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign dir_active = (state_q != DIR_IDLE);

    // A queue write claims the bus on the next cycle.
    assert_wr_claims_R3: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |=> dir_active);

    // Release only ever follows a bit tick.
    assert_release_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(dir_active) |-> $past(bit_tick));

    // The tail counter moves only on ticks.
    assert_tail_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == DIR_TAIL && !bit_tick && !fifo_wr) |=> (state_q == DIR_TAIL && $stable(cnt_q)));

    // A zero tail releases right after the end tick.
    assert_zero_tail_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == DIR_PEND && end_tick && !fifo_wr && tail_cfg == CNT_ZERO) |=> !dir_active);

    // A write during the tail returns to pending.
    assert_tail_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == DIR_TAIL && fifo_wr) |=> (state_q == DIR_PEND));

endmodule

// File: rtl/rs485dir_router.sv
module rs485dir_router
    import rs485dir_pkg::*;
(
    input  dir_cfg_t cfg,
    input  logic     dir_active,
    input  logic     loopback,
    input  logic     modem_rts_n,
    input  logic     modem_dtr_n,
    output logic     rts_pin,
    output logic     dtr_pin
);

    logic dir_lvl;

    assign dir_lvl = dir_level(dir_active, cfg.invert);

    always_comb begin
        rts_pin = modem_rts_n;
        dtr_pin = modem_dtr_n;
        if (loopback) begin
            rts_pin = 1'b1;
            dtr_pin = 1'b1;
        end else if (cfg.auto_en) begin
            if (cfg.use_dtr) dtr_pin = dir_lvl;
            else             rts_pin = dir_lvl;
        end
    end

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
    import rs485dir_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_auto_en,
    input  logic             cfg_use_dtr,
    input  logic             cfg_invert,
    input  logic [DLY_W-1:0] cfg_tail,
    input  logic             loopback,
    input  logic             modem_rts_n,
    input  logic             modem_dtr_n,
    input  logic             bit_tick,
    input  logic             fifo_wr,
    input  logic             fifo_empty,
    input  logic             shifter_idle,
    output logic             rts_pin,
    output logic             dtr_pin
);

    dir_cfg_t cfg;
    logic     dir_active;

    assign cfg = '{auto_en: cfg_auto_en, use_dtr: cfg_use_dtr, invert: cfg_invert};

    rs485dir_tracker #(.DLY_W(DLY_W)) u_tracker (
        .clk          (clk),
        .rst          (rst),
        .bit_tick     (bit_tick),
        .fifo_wr      (fifo_wr),
        .fifo_empty   (fifo_empty),
        .shifter_idle (shifter_idle),
        .tail_cfg     (cfg_tail),
        .dir_active   (dir_active)
    );

    rs485dir_router u_router (
        .cfg         (cfg),
        .dir_active  (dir_active),
        .loopback    (loopback),
        .modem_rts_n (modem_rts_n),
        .modem_dtr_n (modem_dtr_n),
        .rts_pin     (rts_pin),
        .dtr_pin     (dtr_pin)
    );

    assert_disabled_follow_R1: assert property (@(posedge clk) disable iff (rst)
        (!cfg_auto_en && !loopback) |-> (rts_pin == modem_rts_n && dtr_pin == modem_dtr_n));

    assert_loopback_prio_R9: assert property (@(posedge clk) disable iff (rst)
        loopback |-> (rts_pin && dtr_pin));

    assert_unselected_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_auto_en && !loopback) |->
            (cfg_use_dtr ? (rts_pin == modem_rts_n) : (dtr_pin == modem_dtr_n)));

endmodule

// File: tb/rs485_dir_ctrl_bench.sv
module rs485_dir_ctrl_bench;

    localparam int DLY_W = 8;
    localparam int GAP   = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_auto_en = 1'b1;
    logic             cfg_use_dtr = 1'b0;
    logic             cfg_invert = 1'b0;
    logic [DLY_W-1:0] cfg_tail = '0;
    logic             loopback = 1'b0;
    logic             modem_rts_n = 1'b1;
    logic             modem_dtr_n = 1'b1;
    logic             bit_tick = 1'b0;
    logic             fifo_wr = 1'b0;
    logic             fifo_empty = 1'b1;
    logic             shifter_idle = 1'b1;
    logic             rts_pin, dtr_pin;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #4 clk = ~clk;

    rs485_dir_ctrl #(.DLY_W(DLY_W)) u_rs485_dir_ctrl (
        .clk(clk), .rst(rst),
        .cfg_auto_en(cfg_auto_en), .cfg_use_dtr(cfg_use_dtr), .cfg_invert(cfg_invert),
        .cfg_tail(cfg_tail), .loopback(loopback),
        .modem_rts_n(modem_rts_n), .modem_dtr_n(modem_dtr_n),
        .bit_tick(bit_tick), .fifo_wr(fifo_wr), .fifo_empty(fifo_empty),
        .shifter_idle(shifter_idle), .rts_pin(rts_pin), .dtr_pin(dtr_pin)
    );

    function automatic logic exp_rts(input logic act);
        if (loopback) return 1'b1;
        if (cfg_auto_en && !cfg_use_dtr) return ~(act ^ cfg_invert);
        return modem_rts_n;
    endfunction

    function automatic logic exp_dtr(input logic act);
        if (loopback) return 1'b1;
        if (cfg_auto_en && cfg_use_dtr) return ~(act ^ cfg_invert);
        return modem_dtr_n;
    endfunction

    task automatic check_pins(input string tag, input logic act);
        logic er, ed;
        er = exp_rts(act);
        ed = exp_dtr(act);
        n_checks++;
        if (rts_pin !== er || dtr_pin !== ed) begin
            n_fails++;
            $display("FAIL %s: rts=%b dtr=%b expected rts=%b dtr=%b", tag, rts_pin, dtr_pin, er, ed);
        end
    endtask

    task automatic gap();
        repeat (GAP) @(negedge clk);
    endtask

    task automatic pulse_tick();
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    task automatic pulse_wr();
        fifo_wr = 1'b1;
        fifo_empty = 1'b0;
        shifter_idle = 1'b0;
        @(negedge clk);
        fifo_wr = 1'b0;
    endtask

    // Busy ticks, then idle status, then the end tick and a tail of 'tail' ticks.
    task automatic finish_frame(input int busy, input int tail, input string tag);
        for (int i = 0; i < busy; i++) begin
            gap();
            pulse_tick();
            check_pins({tag, " busy R4"}, 1'b1);
        end
        gap();
        fifo_empty = 1'b1;
        shifter_idle = 1'b1;
        gap();
        check_pins({tag, " idle between ticks R4"}, 1'b1);
        cfg_tail = DLY_W'(tail);
        pulse_tick();
        check_pins(tail == 0 ? {tag, " zero tail R6"} : {tag, " end tick R5"}, tail != 0);
        for (int i = 1; i <= tail; i++) begin
            gap();
            check_pins({tag, " between tail ticks R5"}, 1'b1);
            pulse_tick();
            check_pins({tag, " tail count R5"}, i < tail);
        end
    endtask

    task automatic run_frame(input int busy, input int tail, input string tag);
        pulse_wr();
        check_pins({tag, " write claims R3"}, 1'b1);
        finish_frame(busy, tail, tag);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check_pins("reset state R11", 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check_pins("after reset R11", 1'b0);

        // Default polarity on RTS, DTR keeps modem value
        modem_dtr_n = 1'b0;
        run_frame(2, 3, "rts default R2 R10");
        cfg_use_dtr = 1'b1;
        modem_rts_n = 1'b0;
        run_frame(1, 0, "dtr select R2 R10");
        cfg_invert = 1'b1;
        run_frame(3, 2, "invert dtr R7");
        cfg_use_dtr = 1'b0;
        run_frame(0, 1, "invert rts R7");
        cfg_invert = 1'b0;

        // Longest tail
        run_frame(1, 255, "max tail R5");

        // Write during the tail restarts it
        pulse_wr();
        check_pins("restart claim R3", 1'b1);
        gap();
        fifo_empty = 1'b1;
        shifter_idle = 1'b1;
        cfg_tail = DLY_W'(6);
        pulse_tick();
        for (int i = 0; i < 3; i++) begin
            gap();
            pulse_tick();
            check_pins("tail before rewrite R8", 1'b1);
        end
        pulse_wr();
        check_pins("rewrite in tail R8", 1'b1);
        for (int i = 0; i < 4; i++) begin
            gap();
            pulse_tick();
            check_pins("no release after rewrite R8", 1'b1);
        end
        finish_frame(0, 6, "full tail after rewrite R8");

        // Loopback overrides everything
        pulse_wr();
        loopback = 1'b1;
        modem_rts_n = 1'b0;
        modem_dtr_n = 1'b0;
        #1;
        check_pins("loopback R9", 1'b1);
        cfg_invert = 1'b1;
        #1;
        check_pins("loopback inverted R9", 1'b1);
        loopback = 1'b0;
        cfg_invert = 1'b0;
        finish_frame(0, 0, "after loopback R4");

        // Disabled: pins follow modem inputs even while data is pending
        cfg_auto_en = 1'b0;
        pulse_wr();
        check_pins("disabled rts0 dtr0 R1", 1'b1);
        modem_rts_n = 1'b1;
        #1;
        check_pins("disabled rts1 dtr0 R1", 1'b1);
        finish_frame(0, 0, "disabled R1");
        cfg_auto_en = 1'b1;

        // Random frames
        for (int f = 0; f < 40; f++) begin
            cfg_use_dtr = 1'($urandom_range(0, 1));
            cfg_invert  = 1'($urandom_range(0, 1));
            modem_rts_n = 1'($urandom_range(0, 1));
            modem_dtr_n = 1'($urandom_range(0, 1));
            run_frame($urandom_range(0, 4), $urandom_range(0, 12), "random R2 R5 R7 R10");
            repeat ($urandom_range(1, 6)) @(negedge clk);
            check_pins("random idle gap R5", 1'b0);
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule